// File: doc/BRIEF.md
# Quasi-Linear Interpolating Frequency Synthesizer Core

This block is a direct digital frequency synthesizer. A phase accumulator adds an unsigned tuning word on every clock, so the output frequency is the tuning word times the clock rate divided by two to the power of the accumulator width. Only the upper phase bits are kept. They are folded into the first quadrant, and a piecewise polynomial turns the folded phase into a cosine magnitude. The magnitude is then expanded into a full signed cosine sample.

The quadrant is cut into a power-of-two number of equal segments. Segments below a boundary index sit close to the peak and use an even parabola, a constant plus a coefficient times the squared phase. The other segments use a straight line in the phase. Each coefficient is a short list of signed power-of-two terms. Every term is a right shift of the operand. A negative term is inverted bit by bit (ones' complement), so the datapath needs only shifters, conditional inverters and one adder tree. The per-segment constants and term lists are parameters. The defaults give 4 segments, an 11-bit phase and a 10-bit output. A 16-segment, 15-bit-phase, 14-bit-output set is made by overriding the same parameters. A parameterised run of output registers sets the latency without changing the samples.

Top module: `qlip_dds_core`

## Requirements
- R1: A synchronous reset clears the accumulator and all output registers, so `wave` reads 0 while reset is held. After release with a zero tuning word, `wave` shows the phase-0 sample (511 in the default set) once the pipeline has filled.
- R2: After reset, the accumulator grows by `fcw` on every clock, modulo 2^ACC_W. A new tuning word is added on the very next edge, and the phase already reached is kept, so the phase does not jump.
- R3: Only the top PH_W accumulator bits reach the amplitude path. With tuning word 1, the first 2^(ACC_W-PH_W) samples after reset are all equal.
- R4: Phase bit PH_W-2 (the lower quadrant bit) mirrors the in-quadrant offset x to its ones' complement. The XOR of the two top phase bits makes the sample negative. A negative sample is the bitwise inverse of {0, magnitude}. Default examples: phase 1224 and phase 823 give ~414, and phase 1847 gives 414.
- R5: When the segment index (top SEG_LG bits of the folded offset u) is below BOUND, the shift-add terms act on the truncated square u*u >> XW. Default example: phase 200 gives 414.
- R6: When the segment index is at or above BOUND, the terms act on u itself. Default example: phase 300 gives 309.
- R7: Each term is (operand >> shift). It is bitwise inverted when its sign bit is set, and it is zero when the shift field is 31. The sum is the segment constant plus all terms. Each term field is 6 bits: {sign, shift[4:0]}.
- R8: The magnitude is clamped to the range 0 to 2^(OUT_W-1)-1. Default examples: phase 0 gives 511 and phase 512 gives all ones.
- R9: A sample appears PIPE clocks after the accumulator value that produced it.
- R10: The sample at phase p+2^(PH_W-1) is the bitwise inverse of the sample at phase p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | ACC_W | Tuning word added to the phase every clock |
| wave | output | OUT_W | Signed cosine sample, two's-complement format |

## Verification
The embedded assertions check four things on every clock: the accumulator clears under reset, it steps by exactly the tuning word, the sign bit of the formatted sample matches the quadrant decode, and each output register takes the value of the register before it. The sample values themselves can only be judged by the bench's scenarios. These cover the parabola and line arithmetic, the clamp at both ends, the phase truncation and the half-period inversion. The bench compares every sample of a full phase sweep and of random tuning-word runs against a model of the shift-add equations.

// File: rtl/qlip_dds_pkg.sv
package qlip_dds_pkg;
    localparam int NTERM    = 3;   // shift-add terms per segment
    localparam int SH_W     = 5;   // shift amount field width
    localparam int TERM_FW  = SH_W + 1; // {sign, shift}
    localparam int BASE_W   = 16;  // segment constant width
    localparam int SH_OFF   = 31;  // shift code that disables a term
    localparam int SUM_W    = BASE_W + 2;
endpackage

// File: rtl/qlip_phase_acc.sv
module qlip_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] fcw,
    output logic [ACC_W-1:0] acc_q
);
    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_q + fcw;
    end

    // R1: reset clears the phase
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (acc_q == '0));

    // R2: phase advances by the tuning word sampled on the previous edge
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (acc_q == ACC_W'($past(acc_q) + $past(fcw))));
endmodule

// File: rtl/qlip_quadrant_fold.sv
module qlip_quadrant_fold #(
    parameter int ACC_W = 16,
    parameter int PH_W  = 11,
    localparam int XW   = PH_W - 2
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic [XW-1:0]    u_o,
    output logic             neg_o
);
    logic [PH_W-1:0] ph;
    logic [XW-1:0]   x;

    assign ph    = PH_W'(acc_i >> (ACC_W - PH_W));
    assign x     = ph[XW-1:0];
    assign u_o   = ph[PH_W-2] ? ~x : x;
    assign neg_o = ph[PH_W-1] ^ ph[PH_W-2];
endmodule

// File: rtl/qlip_cond_cmpl.sv
module qlip_cond_cmpl #(
    parameter int W = 8
) (
    input  logic         inv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    assign dout = inv ? ~din : din;
endmodule

// File: rtl/qlip_seg_interp.sv
module qlip_seg_interp
    import qlip_dds_pkg::*;
#(
    parameter int XW     = 9,
    parameter int OUT_W  = 10,
    parameter int SEG_LG = 2,
    parameter int BOUND  = 2,
    parameter logic [(1<<SEG_LG)*BASE_W-1:0]        SEG_BASE = '0,
    parameter logic [(1<<SEG_LG)*NTERM*TERM_FW-1:0] TERM_CFG = '0
) (
    input  logic [XW-1:0]      u_i,
    output logic [OUT_W-2:0]   mag_o
);
    localparam int SW = SUM_W;
    localparam logic [SW-1:0] MAXM = SW'((1 << (OUT_W-1)) - 1);

    logic [SEG_LG-1:0] seg;
    logic [2*XW-1:0]   prod;
    logic [XW-1:0]     sq;
    logic [XW-1:0]     opnd;
    logic [BASE_W-1:0] base;
    logic [SW-1:0]     term [NTERM];
    logic [SW-1:0]     total;

    assign seg  = u_i[XW-1 -: SEG_LG];
    assign prod = {{XW{1'b0}}, u_i} * {{XW{1'b0}}, u_i};
    assign sq   = XW'(prod >> XW);
    assign opnd = (int'(seg) < BOUND) ? sq : u_i;
    assign base = SEG_BASE[int'(seg)*BASE_W +: BASE_W];

    for (genvar j = 0; j < NTERM; j++) begin : g_term
        logic [TERM_FW-1:0] cfg;
        logic [SW-1:0]      shifted;
        assign cfg     = TERM_CFG[(int'(seg)*NTERM + j)*TERM_FW +: TERM_FW];
        assign shifted = (cfg[SH_W-1:0] == SH_W'(SH_OFF)) ? '0
                       : ({{(SW-XW){1'b0}}, opnd} >> cfg[SH_W-1:0]);
        qlip_cond_cmpl #(.W(SW)) u_cmpl (
            .inv  (cfg[TERM_FW-1]),
            .din  (shifted),
            .dout (term[j])
        );
    end

    always_comb begin
        total = {{(SW-BASE_W){base[BASE_W-1]}}, base};
        for (int j = 0; j < NTERM; j++) total = total + term[j];
    end

    always_comb begin
        if (total[SW-1])        mag_o = '0;
        else if (total > MAXM)  mag_o = MAXM[OUT_W-2:0];
        else                    mag_o = total[OUT_W-2:0];
    end
endmodule

// File: rtl/qlip_out_pipe.sv
module qlip_out_pipe #(
    parameter int W      = 10,
    parameter int STAGES = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];

    for (genvar k = 1; k < STAGES; k++) begin : g_chk
        // R9: each stage holds what the previous stage held one clock earlier
        p_pipe_shift_r9: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (stg[k] == $past(stg[k-1])));
    end
endmodule

// File: rtl/qlip_dds_core.sv
module qlip_dds_core
    import qlip_dds_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int PH_W   = 11,
    parameter int OUT_W  = 10,
    parameter int SEG_LG = 2,
    parameter int BOUND  = 2,
    parameter int PIPE   = 3,
    parameter logic [(1<<SEG_LG)*BASE_W-1:0] SEG_BASE =
        {16'd780, 16'd696, 16'd513, 16'd514},
    parameter logic [(1<<SEG_LG)*NTERM*TERM_FW-1:0] TERM_CFG =
        {6'h25, 6'h21, 6'h20,
         6'h25, 6'h22, 6'h20,
         6'h1F, 6'h22, 6'h20,
         6'h1F, 6'h22, 6'h20}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] fcw,
    output logic [OUT_W-1:0] wave
);
    localparam int XW = PH_W - 2;

    logic [ACC_W-1:0] acc_q;
    logic [XW-1:0]    u;
    logic             neg;
    logic [OUT_W-2:0] mag;
    logic [OUT_W-1:0] fmt;

    qlip_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk (clk), .rst (rst), .fcw (fcw), .acc_q (acc_q)
    );

    qlip_quadrant_fold #(.ACC_W(ACC_W), .PH_W(PH_W)) u_fold (
        .acc_i (acc_q), .u_o (u), .neg_o (neg)
    );

    qlip_seg_interp #(
        .XW(XW), .OUT_W(OUT_W), .SEG_LG(SEG_LG), .BOUND(BOUND),
        .SEG_BASE(SEG_BASE), .TERM_CFG(TERM_CFG)
    ) u_interp (
        .u_i (u), .mag_o (mag)
    );

    qlip_cond_cmpl #(.W(OUT_W)) u_format (
        .inv (neg), .din ({1'b0, mag}), .dout (fmt)
    );

    qlip_out_pipe #(.W(OUT_W), .STAGES(PIPE)) u_pipe (
        .clk (clk), .rst (rst), .din (fmt), .dout (wave)
    );

    // R4: sign of the formatted sample follows the quadrant decode
    always_comb begin
        p_sign_r4: assert (fmt[OUT_W-1] == neg);
    end
endmodule

// File: tb/qlip_dds_core_tb.sv
`timescale 1ns/1ps
module qlip_dds_core_tb_top;
    localparam int PIPE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] fcw = '0;
    logic [9:0]  wave;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [15:0] macc = '0;
    logic [9:0]  mexp [PIPE];
    logic [10:0] mph  [PIPE];
    bit          mval [PIPE];
    logic [9:0]  cap  [2048];
    bit          capv [2048];

    int base_t [4]    = '{514, 513, 696, 780};
    int sh_t   [4][3] = '{'{0, 2, 31}, '{0, 2, 31}, '{0, 2, 5}, '{0, 1, 5}};
    bit ng_t   [4][3] = '{'{1, 1, 0},  '{1, 1, 0},  '{1, 1, 1}, '{1, 1, 1}};

    qlip_dds_core dut_i (.clk(clk), .rst(rst), .fcw(fcw), .wave(wave));

    always #4 clk = ~clk;

    function automatic logic [9:0] fmodel(input logic [10:0] p);
        int x, u, seg, sq, op, s, t;
        logic [8:0] m;
        x   = int'(p[8:0]);
        u   = p[9] ? 511 - x : x;
        seg = u / 128;
        sq  = (u * u) / 512;
        op  = (seg < 2) ? sq : u;
        s   = base_t[seg];
        for (int j = 0; j < 3; j++) begin
            t = (sh_t[seg][j] == 31) ? 0 : (op >> sh_t[seg][j]);
            s = ng_t[seg][j] ? s - t - 1 : s + t;
        end
        if (s < 0)   s = 0;
        if (s > 511) s = 511;
        m = 9'(s);
        return (p[10] ^ p[9]) ? ~{1'b0, m} : {1'b0, m};
    endfunction

    task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] f, input string tag);
        fcw = f;
        @(posedge clk);
        if (rst) begin
            for (int k = 0; k < PIPE; k++) begin mexp[k] = '0; mph[k] = '0; mval[k] = 1'b0; end
            macc = '0;
        end else begin
            for (int k = PIPE-1; k > 0; k--) begin
                mexp[k] = mexp[k-1]; mph[k] = mph[k-1]; mval[k] = mval[k-1];
            end
            mexp[0] = fmodel(macc[15:5]);
            mph[0]  = macc[15:5];
            mval[0] = 1'b1;
            macc    = macc + f;
        end
        @(negedge clk);
        chk(wave, mexp[PIPE-1], tag);
        if (mval[PIPE-1]) begin
            cap[mph[PIPE-1]]  = wave;
            capv[mph[PIPE-1]] = 1'b1;
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        logic [9:0] first;
        void'($urandom(32'd4471));
        for (int k = 0; k < PIPE; k++) begin mexp[k] = '0; mph[k] = '0; mval[k] = 1'b0; end
        for (int i = 0; i < 2048; i++) capv[i] = 1'b0;

        // R1: reset state
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(16'd0, "R1 reset");
        chk(wave, 10'd0, "R1 held reset output");
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < PIPE + 2; i++) step(16'd0, "R1 R9 fill");
        chk(wave, 10'd511, "R1 phase-zero sample");

        // R3: sub-LSB phase steps leave the sample unchanged
        rst = 1'b1; step(16'd0, "R1 reset"); rst = 1'b0;
        for (int i = 0; i < PIPE; i++) step(16'd1, "R3 fill");
        first = wave;
        for (int i = 0; i < 28; i++) step(16'd1, "R3 truncation");
        chk(wave, first, "R3 constant over low phase bits");

        // Full sweep, one phase word per clock
        rst = 1'b1; step(16'd0, "R1 reset"); rst = 1'b0;
        for (int i = 0; i < 2048 + PIPE; i++) step(16'd32, "R4 R5 R6 R7 R9 sweep");
        chk(cap[0],    10'd511,   "R8 upper clamp at phase 0");
        chk(cap[512],  10'h3FF,   "R8 lower clamp at phase 512");
        chk(cap[200],  10'd414,   "R5 parabola segment");
        chk(cap[100],  10'd489,   "R5 first segment");
        chk(cap[300],  10'd309,   "R6 line segment");
        chk(cap[1224], ~10'd414,  "R4 third quadrant");
        chk(cap[823],  ~10'd414,  "R4 second quadrant mirror");
        chk(cap[1847], 10'd414,   "R4 fourth quadrant mirror");
        for (int p = 0; p < 1024; p++) begin
            if (capv[p] && capv[p+1024]) chk(cap[p+1024], ~cap[p], "R10 half-period inverse");
            else chk(10'd0, 10'd1, "R10 sweep coverage");
        end

        // R2: random tuning words, changed mid-run without reset
        for (int r = 0; r < 24; r++) begin
            logic [15:0] f;
            f = (r % 3 == 0) ? 16'($urandom_range(1, 200)) : 16'($urandom());
            for (int i = 0; i < 80; i++) step(f, "R2 R7 R9 random tuning");
        end

        // R1: reset in the middle of a run
        rst = 1'b1;
        step(16'h1234, "R1 mid-run reset");
        step(16'h1234, "R1 mid-run reset");
        chk(wave, 10'd0, "R1 mid-run reset output");
        rst = 1'b0;
        for (int i = 0; i < 40; i++) step(16'd777, "R2 restart from zero phase");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule